// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is a small processor datapath in which every register transfer travels over one shared internal data bus. Two registers are visible to the instruction stream (R0 and R1). Two hidden operand registers (R2 and R3) sit in front of an ALU. They are loaded only from the bus, and their outputs go only to the ALU inputs. A control sequencer takes one instruction at a time. Each instruction is an opcode, a one-bit source select and a one-bit destination select. The sequencer executes it over one to three clock cycles. In each busy cycle it enables exactly one bus driver and exactly one register load.

The drivers that can reach the bus are R0, R1, the ALU output and a captured immediate value. Each driver is gated by its own enable, which models a tri-state connection. Arithmetic and logic instructions first stage the destination register into R2 and then the source register into R3. In the final cycle the ALU result is driven back onto the bus and loaded into the destination register. A move passes its operand through the ALU with a pass-through code. The data width is a parameter, and a width of one bit is supported as a special case. For this width, add and subtract reduce to exclusive-or.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, R0, R1 and the hidden registers hold zero, busy is low and the bus reads zero.
- R2: Opcode 5 (load immediate) is accepted when busy is low. It captures instr_imm and writes it into the register selected by instr_dst (0 = R0, 1 = R1). Busy is high for exactly one cycle, and the new value is visible once busy falls.
- R3: Opcode 0 (add) writes Rd + Rs, modulo 2^DATA_W, into Rd. Rd is selected by instr_dst and Rs by instr_src. Busy is high for exactly three cycles. The source register keeps its value when it differs from Rd.
- R4: Opcode 1 (subtract) writes Rd - Rs, modulo 2^DATA_W, into Rd, with Rd as the minuend. It takes three busy cycles.
- R5: Opcode 2 writes the bitwise AND of Rd and Rs into Rd. Opcode 3 writes the bitwise OR. Each takes three busy cycles.
- R6: Opcode 4 (move) copies Rs into Rd through the ALU in pass-through mode. Busy is high for exactly two cycles.
- R7: When instr_src equals instr_dst, the operation uses the same register for both operands. For example, add doubles the register and subtract clears it.
- R8: instr_valid is ignored while busy is high. The running instruction completes with its original operands, and no second instruction starts.
- R9: Opcodes 6 and 7 are ignored. Busy stays low, and R0 and R1 keep their values.
- R10: In every busy cycle exactly one source drives the bus. When idle, no source drives it and it reads zero. During an add, the bus carries Rd in the first cycle, Rs in the second cycle and the result in the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present; taken only while busy is low |
| instr_op | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 move, 5 load immediate |
| instr_src | input | 1 | Source register select (0 = R0, 1 = R1) |
| instr_dst | input | 1 | Destination register select (0 = R0, 1 = R1) |
| instr_imm | input | DATA_W | Immediate value for load immediate |
| busy | output | 1 | High while an accepted instruction is executing |
| r0_q | output | DATA_W | Current value of R0 |
| r1_q | output | DATA_W | Current value of R1 |
| bus_q | output | DATA_W | Value on the shared internal bus |

## Verification
The sequencer might pick the wrong driver or load target, or leave a hidden operand stale. Any of these faults corrupts the visible destination register, and the error shows on r0_q or r1_q in the cycle after busy falls. A fault in the sequencer's step count shows at once in the number of cycles that busy stays high. The bus output exposes the staging order cycle by cycle. A wrong operand routed in the first or second cycle is therefore seen in that cycle, before it has any effect on the result.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   localparam int OP_W    = 3;
   localparam int NUM_DRV = 4;
   localparam int NUM_LD  = 4;

   localparam logic [OP_W-1:0] OP_ADD = 3'd0;
   localparam logic [OP_W-1:0] OP_SUB = 3'd1;
   localparam logic [OP_W-1:0] OP_AND = 3'd2;
   localparam logic [OP_W-1:0] OP_OR  = 3'd3;
   localparam logic [OP_W-1:0] OP_MOV = 3'd4;
   localparam logic [OP_W-1:0] OP_LDI = 3'd5;

   localparam int DRV_R0  = 0;
   localparam int DRV_R1  = 1;
   localparam int DRV_ALU = 2;
   localparam int DRV_IMM = 3;

   localparam int LD_R0 = 0;
   localparam int LD_R1 = 1;
   localparam int LD_R2 = 2;
   localparam int LD_R3 = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPA,
      ST_OPB,
      ST_RES,
      ST_IMM
   } seq_state_e;

   typedef enum logic [2:0] {
      FN_PASS,
      FN_ADD,
      FN_SUB,
      FN_AND,
      FN_OR
   } alu_fn_e;

   function automatic seq_state_e first_step(input logic [OP_W-1:0] op);
      case (op)
         OP_ADD, OP_SUB, OP_AND, OP_OR: first_step = ST_OPA;
         OP_MOV:                        first_step = ST_OPB;
         OP_LDI:                        first_step = ST_IMM;
         default:                       first_step = ST_IDLE;
      endcase
   endfunction

   function automatic alu_fn_e result_fn(input logic [OP_W-1:0] op);
      case (op)
         OP_ADD:  result_fn = FN_ADD;
         OP_SUB:  result_fn = FN_SUB;
         OP_AND:  result_fn = FN_AND;
         OP_OR:   result_fn = FN_OR;
         default: result_fn = FN_PASS;
      endcase
   endfunction

   function automatic int vis_drv(input logic sel);
      vis_drv = sel ? DRV_R1 : DRV_R0;
   endfunction

   function automatic int vis_ld(input logic sel);
      vis_ld = sel ? LD_R1 : LD_R0;
   endfunction

endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
   import sbus_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                instr_valid,
   input  logic [OP_W-1:0]     instr_op,
   input  logic                instr_src,
   input  logic                instr_dst,
   output logic                accept,
   output logic                busy,
   output logic [NUM_DRV-1:0]  drv_en,
   output logic [NUM_LD-1:0]   ld_en,
   output alu_fn_e             alu_fn
);

   seq_state_e      state_q;
   seq_state_e      state_d;
   logic [OP_W-1:0] op_q;
   logic            src_q;
   logic            dst_q;

   assign busy   = (state_q != ST_IDLE);
   assign accept = instr_valid && !busy && (first_step(instr_op) != ST_IDLE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept) state_d = first_step(instr_op);
         ST_OPA:  state_d = ST_OPB;
         ST_OPB:  state_d = ST_RES;
         ST_RES:  state_d = ST_IDLE;
         ST_IMM:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         src_q   <= 1'b0;
         dst_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_q  <= instr_op;
            src_q <= instr_src;
            dst_q <= instr_dst;
         end
      end
   end

   always_comb begin
      drv_en = '0;
      ld_en  = '0;
      alu_fn = FN_PASS;
      case (state_q)
         ST_OPA: begin
            drv_en[vis_drv(dst_q)] = 1'b1;
            ld_en[LD_R2]           = 1'b1;
         end
         ST_OPB: begin
            drv_en[vis_drv(src_q)] = 1'b1;
            ld_en[LD_R3]           = 1'b1;
         end
         ST_RES: begin
            drv_en[DRV_ALU]       = 1'b1;
            ld_en[vis_ld(dst_q)]  = 1'b1;
            alu_fn                = result_fn(op_q);
         end
         ST_IMM: begin
            drv_en[DRV_IMM]       = 1'b1;
            ld_en[vis_ld(dst_q)]  = 1'b1;
         end
         default: ;
      endcase
   end

   // R10
   busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(ld_en) == 1));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (drv_en == '0) && (ld_en == '0));

   // R8
   hold_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && instr_valid) |=> $stable(op_q) && $stable(dst_q) && $stable(src_q));

   // R9
   unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && instr_valid && (instr_op > OP_LDI)) |=> !busy);

endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
   parameter int DATA_W  = 8,
   parameter int NUM_SRC = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             drv_en,
   input  logic [NUM_SRC-1:0][DATA_W-1:0] src_data,
   output logic [DATA_W-1:0]              bus
);

   logic [NUM_SRC-1:0][DATA_W-1:0] gated;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_drv
      assign gated[i] = src_data[i] & {DATA_W{drv_en[i]}};
   end

   always_comb begin
      bus = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         bus = bus | gated[i];
      end
   end

   // R10
   bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_en));

endmodule

// File: rtl/sbus_regbank.sv
module sbus_regbank #(
   parameter int DATA_W  = 8,
   parameter int NUM_REG = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_REG-1:0]             ld_en,
   input  logic [DATA_W-1:0]              bus,
   output logic [NUM_REG-1:0][DATA_W-1:0] q
);

   for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= '0;
         else if (ld_en[i])
            q[i] <= bus;
      end

      // R3
      reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ld_en[i] |=> $stable(q[i]));
   end

   // R10
   ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_en));

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_fn_e           fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] diff;

   if (DATA_W == 1) begin : g_bit
      assign sum  = a ^ b;
      assign diff = a ^ b;
   end else begin : g_word
      assign sum  = a + b;
      assign diff = a - b;
   end

   always_comb begin
      case (fn)
         FN_ADD:  y = sum;
         FN_SUB:  y = diff;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         default: y = b;
      endcase
   end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [2:0]        instr_op,
   input  logic              instr_src,
   input  logic              instr_dst,
   input  logic [DATA_W-1:0] instr_imm,
   output logic              busy,
   output logic [DATA_W-1:0] r0_q,
   output logic [DATA_W-1:0] r1_q,
   output logic [DATA_W-1:0] bus_q
);

   if (DATA_W < 1) begin : g_bad_width
      $error("sbus_datapath: DATA_W must be at least 1");
   end

   logic                           accept;
   logic [NUM_DRV-1:0]             drv_en;
   logic [NUM_LD-1:0]              ld_en;
   alu_fn_e                        alu_fn;
   logic [NUM_LD-1:0][DATA_W-1:0]  regs;
   logic [NUM_DRV-1:0][DATA_W-1:0] src_data;
   logic [DATA_W-1:0]              alu_y;
   logic [DATA_W-1:0]              imm_q;
   logic [DATA_W-1:0]              bus;

   sbus_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_op    (instr_op),
      .instr_src   (instr_src),
      .instr_dst   (instr_dst),
      .accept      (accept),
      .busy        (busy),
      .drv_en      (drv_en),
      .ld_en       (ld_en),
      .alu_fn      (alu_fn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         imm_q <= '0;
      else if (accept)
         imm_q <= instr_imm;
   end

   assign src_data[DRV_R0]  = regs[LD_R0];
   assign src_data[DRV_R1]  = regs[LD_R1];
   assign src_data[DRV_ALU] = alu_y;
   assign src_data[DRV_IMM] = imm_q;

   sbus_bus #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_DRV)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv_en   (drv_en),
      .src_data (src_data),
      .bus      (bus)
   );

   sbus_regbank #(
      .DATA_W  (DATA_W),
      .NUM_REG (NUM_LD)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_en (ld_en),
      .bus   (bus),
      .q     (regs)
   );

   sbus_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .fn (alu_fn),
      .a  (regs[LD_R2]),
      .b  (regs[LD_R3]),
      .y  (alu_y)
   );

   assign r0_q  = regs[LD_R0];
   assign r1_q  = regs[LD_R1];
   assign bus_q = bus;

   // R10
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus == '0));

   // R2
   imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (instr_op == OP_LDI)) |=> busy ##1 !busy);

endmodule

// File: tb/tb_sbus_datapath.sv
`timescale 1ns/1ps
module tb_sbus_datapath;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         instr_valid = 1'b0;
   logic [2:0]   instr_op = '0;
   logic         instr_src = 1'b0;
   logic         instr_dst = 1'b0;
   logic [W-1:0] instr_imm = '0;
   logic         busy;
   logic [W-1:0] r0_q;
   logic [W-1:0] r1_q;
   logic [W-1:0] bus_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   sbus_datapath #(.DATA_W(W)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_op    (instr_op),
      .instr_src   (instr_src),
      .instr_dst   (instr_dst),
      .instr_imm   (instr_imm),
      .busy        (busy),
      .r0_q        (r0_q),
      .r1_q        (r1_q),
      .bus_q       (bus_q)
   );

   // fields: op[39:36] src[35:32] dst[31:28] imm[27:20] r0[19:12] r1[11:4] cycles[3:0]
   localparam int NV = 14;
   localparam logic [39:0] VEC [NV] = '{
      40'h5_0_0_5A_5A_00_1,
      40'h5_0_1_33_5A_33_1,
      40'h0_1_0_00_8D_33_3,
      40'h1_0_1_00_8D_A6_3,
      40'h2_1_0_00_84_A6_3,
      40'h5_0_1_11_84_11_1,
      40'h3_1_0_00_95_11_3,
      40'h4_0_1_00_95_95_2,
      40'h0_1_1_00_95_2A_3,
      40'h1_0_0_00_00_2A_3,
      40'h5_0_0_FF_FF_2A_1,
      40'h0_1_0_00_29_2A_3,
      40'h6_0_0_77_29_2A_0,
      40'h7_1_1_77_29_2A_0
   };

   function automatic string req_of(input logic [3:0] op, input logic s, input logic d);
      if (op < 4'd6 && op != 4'd5 && s == d) return "R7";
      case (op)
         4'd0: return "R3";
         4'd1: return "R4";
         4'd2, 4'd3: return "R5";
         4'd4: return "R6";
         4'd5: return "R2";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic s, input logic d,
                        input logic [W-1:0] imm, output int ncyc);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_op    = op;
      instr_src   = s;
      instr_dst   = d;
      instr_imm   = imm;
      @(negedge clk);
      instr_valid = 1'b0;
      ncyc = 0;
      while (busy && ncyc < 20) begin
         ncyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "r0 after reset", r0_q, 0);
      check("R1", "r1 after reset", r1_q, 0);
      check("R1", "busy after reset", busy, 0);
      check("R1", "bus after reset", bus_q, 0);

      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         string rq;
         v  = VEC[i];
         rq = req_of(v[39:36], v[32], v[28]);
         issue(v[38:36], v[32], v[28], v[27:20], n);
         check(rq, "busy cycles", n, int'(v[3:0]));
         check(rq, "r0", r0_q, int'(v[19:12]));
         check(rq, "r1", r1_q, int'(v[11:4]));
      end

      // R10 bus staging order for ADD R1,R0 (r0=29, r1=2A), with R8 valid held while busy
      @(negedge clk);
      instr_valid = 1'b1;
      instr_op    = 3'd0;
      instr_src   = 1'b0;
      instr_dst   = 1'b1;
      @(negedge clk);
      check("R10", "bus cycle 1 carries Rd", bus_q, 8'h2A);
      check("R10", "busy cycle 1", busy, 1);
      instr_op    = 3'd5;
      instr_dst   = 1'b1;
      instr_imm   = 8'h00;
      @(negedge clk);
      check("R10", "bus cycle 2 carries Rs", bus_q, 8'h29);
      instr_valid = 1'b0;
      @(negedge clk);
      check("R10", "bus cycle 3 carries result", bus_q, 8'h53);
      @(negedge clk);
      check("R8", "r1 after add with valid held", r1_q, 8'h53);
      check("R8", "busy low after add", busy, 0);
      check("R10", "bus idle reads zero", bus_q, 0);
      @(negedge clk);
      check("R8", "no second instruction started", busy, 0);
      check("R8", "r1 unchanged after", r1_q, 8'h53);
      check("R3", "source unchanged", r0_q, 8'h29);

      // R9 unused opcode while idle leaves bus quiet
      @(negedge clk);
      instr_valid = 1'b1;
      instr_op    = 3'd6;
      @(negedge clk);
      instr_valid = 1'b0;
      check("R9", "busy after opcode 6", busy, 0);
      check("R9", "bus after opcode 6", bus_q, 0);
      check("R9", "r0 after opcode 6", r0_q, 8'h29);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule